// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block turns a linear byte address from an on-chip bus master into the two halves of a DRAM address: a row and a column. Both halves go out on the same low-order address pins, one after the other. The DRAM timing sequencer chooses which half is presented with a single phase input. It holds that input low for the row half and raises it for the column half. The pin value is registered, so it settles one clock before the strobe that follows.

The split depends on two configuration inputs. The first is a four-bit bank-depth code, covering 128K to 16M words in powers of two. The second selects a 16-bit or 32-bit data port. For a word-address width of N bits, the column takes the lower floor(N/2) bits of the word address and the row takes the upper ceil(N/2) bits. Both halves are placed on the pins starting at the lowest word-address bit, which is bit 1 for a 16-bit port and bit 2 for a 32-bit port. Every pin outside the selected field is driven low.

Top module: `dram_rc_mux`

## Requirements
- R1: While rst_n is low, pin_addr is all zeros.
- R2: A bank code c in 0..7 selects a depth of 2^(17+c) words, so the word address is N = 17+c bits wide.
- R3: The column field is the lower floor(N/2) bits of the word address, and the row field is the next ceil(N/2) bits above it.
- R4: With port_32 = 0 the word address starts at byte bit 1 and the fields sit on pins from bit 1 upward. With port_32 = 1 both start at bit 2, and pin bits 1 and 0 stay zero.
- R5: col_phase = 0 selects the row field and col_phase = 1 selects the column field. The selection appears on pin_addr after the next rising clock edge.
- R6: Pin bits below the field start, and pin bits above the selected field's top bit, are zero.
- R7: Bank codes 8..15 are illegal and behave exactly like code 0 (128K words: 8 column bits, 9 row bits).
- R8: Byte address bits above the bank's word range, and the byte-lane bits below the word address, have no effect on pin_addr.
- R9: With a 16-bit port and a 512K depth (code 2), the row phase outputs address bits 19..10 on pins 10..1 and the column phase outputs address bits 9..1 on pins 9..1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_addr | input | ADDR_W | Linear byte address from the bus master |
| bank_code | input | 4 | Bank depth code (0..7 legal) |
| port_32 | input | 1 | 1 = 32-bit data port, 0 = 16-bit |
| col_phase | input | 1 | 0 = row half, 1 = column half |
| pin_addr | output | ADDR_W | Registered multiplexed DRAM address pins |

## Verification
The bench builds the block with its default ADDR_W of 28. That width is enough to carry a 16M-word bank on a 32-bit port and still leave several byte-address bits above the largest bank. Those spare bits let the bench set high address bits and confirm that they never reach the pins. The sweep covers all sixteen bank codes, so every legal split from 8/9 up to 12/12 is exercised with both port widths, and every illegal code is compared against code 0.

// File: rtl/dram_rc_pkg.sv
package dram_rc_pkg;
  localparam int BASE_LOG2  = 17;
  localparam int CODE_W     = 4;
  localparam int NUM_DEPTHS = 8;
  localparam int MAX_WBITS  = BASE_LOG2 + NUM_DEPTHS - 1;
  localparam int MAX_FIELD  = (MAX_WBITS + 1) / 2;
  localparam int CNT_W      = 5;

  typedef struct packed {
    logic [CNT_W-1:0] cols;
    logic [CNT_W-1:0] rows;
    logic [1:0]       shift;
  } geom_t;

  function automatic logic code_ok(input logic [CODE_W-1:0] code);
    return int'(code) < NUM_DEPTHS;
  endfunction

  function automatic logic [CNT_W-1:0] word_bits(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] eff;
    eff = code_ok(code) ? code : '0;
    return CNT_W'(BASE_LOG2) + CNT_W'(eff);
  endfunction

  function automatic geom_t make_geom(input logic [CODE_W-1:0] code, input logic wide);
    geom_t g;
    logic [CNT_W-1:0] n;
    n       = word_bits(code);
    g.cols  = n >> 1;
    g.rows  = n - (n >> 1);
    g.shift = wide ? 2'd2 : 2'd1;
    return g;
  endfunction
endpackage

// File: rtl/dram_geom_decode.sv
module dram_geom_decode
  import dram_rc_pkg::*;
(
  input  logic [CODE_W-1:0] bank_code,
  input  logic              port_32,
  output geom_t             geom,
  output logic              code_legal
);
  assign geom       = make_geom(bank_code, port_32);
  assign code_legal = code_ok(bank_code);
endmodule

// File: rtl/dram_field_split.sv
module dram_field_split
  import dram_rc_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic [ADDR_W-1:0]    byte_addr,
  input  geom_t                geom,
  output logic [MAX_FIELD-1:0] row_field,
  output logic [MAX_FIELD-1:0] col_field
);
  logic [MAX_FIELD-1:0] col_src;
  logic [MAX_FIELD-1:0] row_src;

  assign col_src = MAX_FIELD'(byte_addr >> geom.shift);
  assign row_src = MAX_FIELD'((byte_addr >> geom.shift) >> geom.cols);

  for (genvar i = 0; i < MAX_FIELD; i++) begin : g_bit
    assign col_field[i] = (CNT_W'(i) < geom.cols) & col_src[i];
    assign row_field[i] = (CNT_W'(i) < geom.rows) & row_src[i];
  end
endmodule

// File: rtl/dram_pin_drive.sv
module dram_pin_drive
  import dram_rc_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 col_phase,
  input  logic [MAX_FIELD-1:0] row_field,
  input  logic [MAX_FIELD-1:0] col_field,
  input  logic [1:0]           shift,
  output logic [ADDR_W-1:0]    pin_addr
);
  logic [MAX_FIELD-1:0] sel_field;
  logic [ADDR_W-1:0]    placed;

  assign sel_field = col_phase ? col_field : row_field;
  assign placed    = ADDR_W'(sel_field) << shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_addr <= '0;
    else        pin_addr <= placed;
  end
endmodule

// File: rtl/dram_rc_mux.sv
module dram_rc_mux
  import dram_rc_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [CODE_W-1:0] bank_code,
  input  logic              port_32,
  input  logic              col_phase,
  output logic [ADDR_W-1:0] pin_addr
);
  geom_t                geom;
  logic                 code_legal;
  logic [MAX_FIELD-1:0] row_field;
  logic [MAX_FIELD-1:0] col_field;

  dram_geom_decode u_geom (
    .bank_code (bank_code),
    .port_32   (port_32),
    .geom      (geom),
    .code_legal(code_legal)
  );

  dram_field_split #(.ADDR_W(ADDR_W)) u_split (
    .byte_addr(byte_addr),
    .geom     (geom),
    .row_field(row_field),
    .col_field(col_field)
  );

  dram_pin_drive #(.ADDR_W(ADDR_W)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .col_phase(col_phase),
    .row_field(row_field),
    .col_field(col_field),
    .shift    (geom.shift),
    .pin_addr (pin_addr)
  );
endmodule

// File: rtl/dram_rc_mux_chk.sv
module dram_rc_mux_chk
  import dram_rc_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 col_phase,
  input logic                 port_32,
  input logic [CODE_W-1:0]    bank_code,
  input logic [ADDR_W-1:0]    pin_addr,
  input geom_t                geom,
  input logic                 code_legal,
  input logic [MAX_FIELD-1:0] row_field,
  input logic [MAX_FIELD-1:0] col_field
);
  AST_BYTE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pin_addr[0] == 1'b0); // R4
  AST_WIDE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    port_32 |=> pin_addr[1] == 1'b0); // R4
  AST_ROW_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !col_phase |=> pin_addr == (ADDR_W'($past(row_field)) << $past(geom.shift))); // R5
  AST_COL_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    col_phase |=> pin_addr == (ADDR_W'($past(col_field)) << $past(geom.shift))); // R5
  AST_ROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !col_phase |=> (pin_addr >> ($past(geom.shift) + $past(geom.rows))) == '0); // R6
  AST_COL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    col_phase |=> (pin_addr >> ($past(geom.shift) + $past(geom.cols))) == '0); // R6
  AST_SPLIT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (geom.rows >= geom.cols) && (geom.rows - geom.cols <= CNT_W'(1))); // R3
  AST_ILLEGAL_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    !code_legal |-> (int'(geom.cols) == BASE_LOG2 / 2) &&
                    (int'(geom.rows) == BASE_LOG2 - BASE_LOG2 / 2)); // R7
  AST_LEGAL_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    code_legal |-> int'(geom.cols) + int'(geom.rows) == BASE_LOG2 + int'(bank_code)); // R2
endmodule

bind dram_rc_mux dram_rc_mux_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .col_phase (col_phase),
  .port_32   (port_32),
  .bank_code (bank_code),
  .pin_addr  (pin_addr),
  .geom      (geom),
  .code_legal(code_legal),
  .row_field (row_field),
  .col_field (col_field)
);

// File: tb/dram_rc_mux_tb_top.sv
module dram_rc_mux_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 28;
  localparam int VW = AW + 4 + 1 + 1 + AW;
  localparam int NV = 9;

  // {addr, code, port_32, col_phase, expected pins}
  localparam logic [VW-1:0] VECS [0:NV-1] = '{
    {28'h00ABCDE, 4'd2, 1'b0, 1'b0, 28'h000055E},  // R9 row
    {28'h00ABCDE, 4'd2, 1'b0, 1'b1, 28'h00000DE},  // R9 column
    {28'h00ABCDE, 4'd9, 1'b0, 1'b0, 28'h00002BC},  // R7 row
    {28'h00ABCDE, 4'd9, 1'b0, 1'b1, 28'h00000DE},  // R7 column
    {28'hFFFFFFF, 4'd7, 1'b1, 1'b0, 28'h0003FFC},  // R8 row
    {28'hFFFFFFF, 4'd0, 1'b1, 1'b1, 28'h00003FC},  // R4 column
    {28'hFFFFFFF, 4'd0, 1'b1, 1'b0, 28'h00007FC},  // R4 row
    {28'h1234567, 4'd7, 1'b0, 1'b1, 28'h0000566},  // R3 column
    {28'h1234567, 4'd7, 1'b0, 1'b0, 28'h0001234}   // R3 row
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] byte_addr = '0;
  logic [3:0]    bank_code = '0;
  logic          port_32 = 1'b0;
  logic          col_phase = 1'b0;
  logic [AW-1:0] pin_addr;
  int            n_checks = 0;
  int            n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_rc_mux #(.ADDR_W(AW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_addr(byte_addr),
    .bank_code(bank_code),
    .port_32  (port_32),
    .col_phase(col_phase),
    .pin_addr (pin_addr)
  );

  function automatic logic [AW-1:0] model(input logic [AW-1:0] a, input int code,
                                         input bit wide, input bit col);
    longint lanes = wide ? 4 : 2;
    int     eff   = (code > 7) ? 0 : code;
    int     n     = 17 + eff;
    int     c     = n / 2;
    int     r     = n - c;
    longint word  = longint'(a) / lanes;
    longint cpart = word % (longint'(1) << c);
    longint rpart = (word / (longint'(1) << c)) % (longint'(1) << r);
    return AW'((col ? cpart : rpart) * lanes);
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [AW-1:0] a, input int code, input bit wide, input bit col);
    @(negedge clk);
    byte_addr = a; bank_code = 4'(code); port_32 = wide; col_phase = col;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] base;
    byte_addr = 28'h5A5A5A5; col_phase = 1'b1; bank_code = 4'd5;
    repeat (3) @(negedge clk);
    check("R1 reset", pin_addr, '0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VECS[v];
      apply(e[VW-1 -: AW], int'(e[AW+5:AW+2]), e[AW+1], e[AW]);
      check($sformatf("R5 table vector %0d", v), pin_addr, e[AW-1:0]);
    end

    // R2 R6 sweep over every code, port width and phase
    for (int code = 0; code < 16; code++)
      for (int w = 0; w < 2; w++)
        for (int ph = 0; ph < 2; ph++)
          for (int k = 0; k < 3; k++) begin
            logic [AW-1:0] a;
            a = AW'(32'h9E3779B9 * (code * 4 + w * 2 + ph + k * 97 + 1));
            apply(a, code, w[0], ph[0]);
            check($sformatf("R2 R6 sweep code %0d w %0d ph %0d", code, w, ph),
                  pin_addr, model(a, code, w[0], ph[0]));
          end

    // R7 illegal codes equal code 0
    for (int code = 8; code < 16; code++) begin
      apply(28'h3C96A5B, code, 1'b1, 1'b0);
      check($sformatf("R7 code %0d", code), pin_addr, model(28'h3C96A5B, 0, 1'b1, 1'b0));
    end

    // R8 high bits and byte-lane bits are ignored
    base = 28'h00ABCDE;
    apply(base, 2, 1'b0, 1'b0);
    check("R8 base row", pin_addr, 28'h000055E);
    apply(base | 28'hFF00001, 2, 1'b0, 1'b0);
    check("R8 high bits row", pin_addr, 28'h000055E);
    apply(base | 28'hFF00001, 2, 1'b0, 1'b1);
    check("R8 high bits column", pin_addr, 28'h00000DE);
    apply(28'h0000003, 3, 1'b1, 1'b1);
    check("R8 lane bits wide", pin_addr, '0);

    // R4 wide port keeps pin bits 1..0 at zero with all-ones address
    apply('1, 4, 1'b1, 1'b1);
    check("R4 wide column", pin_addr, 28'h0000FFC);

    // R1 reset mid-run clears the pins
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", pin_addr, '0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule